// File: doc/BRIEF.md
# Side-by-Side Line Merge Unit

This block takes pixel lines from a left stream and a right stream and emits one wider line per row: the left segment first, then the right segment. It can also run with one input only. In that case the same two line stores are chained, so that a line fills the first store, moves into the second, and drains from there. The right width chooses between the two uses. A non-zero right width selects joining, and a zero right width selects chained buffering.

Software programs the block through a small write-only register port. The port holds a control word with the enable bit, a mute bit, a left size word, a right width, and a 5-bit mode code. The size and mode values are copied into working registers only when the unit is started. After that, writes to them have no effect until the unit is stopped and started again. All pixel interfaces use valid/ready handshakes. The output marks the end of each line and the end of each frame.

Top module: `lr_line_joiner`

## Requirements
- R1: Register addresses are 0 for control, 1 for mute, 2 for the left size, 3 for the right width and 4 for the mode code. The left size word holds the frame height in bits 31:16 and the left width in bits 15:0. The right word holds the right width in bits 15:0.
- R2: From the cycle after a start is accepted, `out_size` reads the height in bits 31:16 and the sum of the left and right widths in bits 15:0.
- R3: With a non-zero right width, the unit is in join mode. Each output line is the next left line of left-width pixels in arrival order, followed by the next right line of right-width pixels.
- R4: With a right width of zero, the unit is in chained buffer mode. The output is the left stream in order, cut into lines of left-width pixels, and `r_ready` stays low.
- R5: A start is refused if any of the following holds:
  - the height is zero;
  - the left width is zero;
  - either width exceeds MAX_W;
  - the mode code does not fit the width. Code 18 needs a non-zero right width, and codes 6 or 8 need a zero right width.
  After a refused start, both input readies stay low.
- R6: Writing 1 to control bit 0 starts the unit. Writing 0 stops it: the next cycle `l_ready`, `r_ready` and `o_valid` are low and partly filled lines are discarded. After reset the unit is stopped.
- R7: While mute bit 0 is 1, `o_valid` is low. No pixel is lost, and output resumes in order once mute is cleared.
- R8: Size and mode writes made while running change neither `out_size` nor the line geometry until the next start.
- R9: A joined line starts only once both stores hold a complete line. The faster input is stalled, so the left input gets at most one line ahead of the right.
- R10: `o_eol` marks the last pixel of each output line. `o_eof` marks the last pixel of every height-th line. Line counting restarts at each start.
- R11: While running and unmuted, a valid output that is not accepted stays valid with unchanged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| l_valid | input | 1 | Left pixel valid |
| l_ready | output | 1 | Left pixel ready |
| l_data | input | PIX_W | Left pixel |
| r_valid | input | 1 | Right pixel valid |
| r_ready | output | 1 | Right pixel ready |
| r_data | input | PIX_W | Right pixel |
| o_valid | output | 1 | Output pixel valid |
| o_ready | input | 1 | Output pixel ready |
| o_data | output | PIX_W | Output pixel |
| o_eol | output | 1 | Last pixel of a line |
| o_eof | output | 1 | Last pixel of a frame |
| out_size | output | 32 | Output size word of the running configuration |

## Verification
Assertions check the following on every cycle:
- a start never comes from a rejected configuration;
- the working geometry stays frozen while running;
- mute suppresses `o_valid`;
- a held output stays stable;
- the right input is idle in buffer mode;
- the line counter stays inside the frame;
- `o_eof` only coincides with `o_eol`.

Only the bench scenarios can show the following:
- that the pixel order, the segment widths and the line and frame markers are correct over whole frames;
- that stalling the right input holds the left exactly one line ahead;
- that a stop discards partial lines.

// File: rtl/ljn_pkg.sv
package ljn_pkg;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_MUTE  = 3'd1;
  localparam logic [2:0] REG_LSIZE = 3'd2;
  localparam logic [2:0] REG_RSIZE = 3'd3;
  localparam logic [2:0] REG_MODE  = 3'd4;

  localparam logic [4:0] CODE_BUF_SINGLE = 5'd6;
  localparam logic [4:0] CODE_BUF_DUAL   = 5'd8;
  localparam logic [4:0] CODE_JOIN       = 5'd18;

  typedef enum logic {SEG_LEFT, SEG_RIGHT} seg_e;

  // mode code must agree with the width-derived mode
  function automatic logic code_fits(input logic [4:0] code, input logic join_sel);
    if (join_sel) return code == CODE_JOIN;
    return (code == CODE_BUF_SINGLE) || (code == CODE_BUF_DUAL);
  endfunction

endpackage

// File: rtl/ljn_cfg.sv
module ljn_cfg
  import ljn_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int CNT_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic             run_o,
  output logic             mute_o,
  output logic             join_o,
  output logic [15:0]      h_o,
  output logic [CNT_W-1:0] lw_o,
  output logic [CNT_W-1:0] rw_o,
  output logic [31:0]      size_o
);

  logic             mute_q, run_q, run_d;
  logic [31:0]      lsz_q;
  logic [15:0]      rwr_q;
  logic [4:0]       code_q;
  logic [15:0]      h_q;
  logic [CNT_W-1:0] lw_q, rw_q;

  logic ctrl_wr, mute_we, lsz_we, rsz_we, code_we;
  logic cfg_ok, load;

  always_comb begin
    ctrl_wr = we_i && (addr_i == REG_CTRL);
    mute_we = we_i && (addr_i == REG_MUTE);
    lsz_we  = we_i && (addr_i == REG_LSIZE);
    rsz_we  = we_i && (addr_i == REG_RSIZE);
    code_we = we_i && (addr_i == REG_MODE);
    cfg_ok  = (lsz_q[31:16] != 16'd0) && (lsz_q[15:0] != 16'd0)
           && (lsz_q[15:0] <= 16'(MAX_W)) && (rwr_q <= 16'(MAX_W))
           && code_fits(code_q, rwr_q != 16'd0);
    load  = ctrl_wr && wdata_i[0] && !run_q && cfg_ok;
    run_d = run_q;
    if (ctrl_wr) run_d = wdata_i[0] ? (run_q || cfg_ok) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mute_q <= 1'b0;
      lsz_q  <= '0;
      rwr_q  <= '0;
      code_q <= '0;
      h_q    <= '0;
      lw_q   <= '0;
      rw_q   <= '0;
    end else begin
      run_q <= run_d;
      if (mute_we) mute_q <= wdata_i[0];
      if (lsz_we)  lsz_q  <= wdata_i;
      if (rsz_we)  rwr_q  <= wdata_i[15:0];
      if (code_we) code_q <= wdata_i[4:0];
      if (load) begin
        h_q  <= lsz_q[31:16];
        lw_q <= lsz_q[CNT_W-1:0];
        rw_q <= rwr_q[CNT_W-1:0];
      end
    end
  end

  assign run_o  = run_q;
  assign mute_o = mute_q;
  assign join_o = (rw_q != '0);
  assign h_o    = h_q;
  assign lw_o   = lw_q;
  assign rw_o   = rw_q;
  assign size_o = {h_q, 16'(lw_q) + 16'(rw_q)};

  assert_start_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !$past(run_q)) |-> $past(cfg_ok));

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(h_q) && $stable(lw_q) && $stable(rw_q)));

endmodule

// File: rtl/ljn_line_buf.sv
module ljn_line_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [AW-1:0] last_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [DW-1:0] wr_data_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_last_o
);

  logic [DW-1:0] mem [DEPTH];
  logic          full_q, full_d;
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic          wr_fire, rd_fire, wr_end, rd_end;

  always_comb begin
    wr_fire = wr_valid_i && !full_q && !clr_i;
    rd_fire = rd_ready_i && full_q && !clr_i;
    wr_end  = wptr_q == last_i;
    rd_end  = rptr_q == last_i;
    full_d  = full_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    if (clr_i) begin
      full_d = 1'b0;
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (wr_fire) begin
        wptr_d = wr_end ? '0 : AW'(wptr_q + 1'b1);
        if (wr_end) full_d = 1'b1;
      end
      if (rd_fire) begin
        rptr_d = rd_end ? '0 : AW'(rptr_q + 1'b1);
        if (rd_end) full_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      full_q <= full_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr_q] <= wr_data_i;
  end

  assign wr_ready_o = !full_q && !clr_i;
  assign rd_valid_o = full_q && !clr_i;
  assign rd_data_o  = mem[rptr_q];
  assign rd_last_o  = rd_end;

  assert_wptr_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !full_q) |-> (wptr_q <= last_i));

endmodule

// File: rtl/ljn_out_seq.sv
module ljn_out_seq
  import ljn_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          mute_i,
  input  logic          join_i,
  input  logic [15:0]   h_i,
  input  logic          b0_valid_i,
  input  logic [DW-1:0] b0_data_i,
  input  logic          b0_last_i,
  input  logic          b1_valid_i,
  input  logic [DW-1:0] b1_data_i,
  input  logic          b1_last_i,
  output logic          b0_ready_o,
  output logic          b1_ready_o,
  output logic          o_valid_o,
  input  logic          o_ready_i,
  output logic [DW-1:0] o_data_o,
  output logic          o_eol_o,
  output logic          o_eof_o
);

  seg_e        seg_q, seg_d;
  logic [15:0] row_q, row_d;
  logic        seg_left, src_valid, fire, line_end, frame_end;

  always_comb begin
    seg_left  = join_i && (seg_q == SEG_LEFT);
    src_valid = seg_left ? (b0_valid_i && b1_valid_i) : b1_valid_i;
    o_valid_o = run_i && !mute_i && src_valid;
    o_data_o  = seg_left ? b0_data_i : b1_data_i;
    fire      = o_valid_o && o_ready_i;
    b0_ready_o = fire && seg_left;
    b1_ready_o = fire && !seg_left;
    line_end  = !seg_left && b1_last_i;
    frame_end = row_q == (h_i - 16'd1);
    o_eol_o   = o_valid_o && line_end;
    o_eof_o   = o_eol_o && frame_end;

    seg_d = seg_q;
    row_d = row_q;
    if (!run_i) begin
      seg_d = SEG_LEFT;
      row_d = '0;
    end else if (fire) begin
      if (seg_left && b0_last_i) seg_d = SEG_RIGHT;
      if (line_end) begin
        seg_d = SEG_LEFT;
        row_d = frame_end ? 16'd0 : row_q + 16'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_LEFT;
      row_q <= '0;
    end else begin
      seg_q <= seg_d;
      row_q <= row_d;
    end
  end

  assert_row_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (row_q < h_i));

  assert_eof_on_eol_R10: assert property (@(posedge clk) disable iff (!rst_n)
    o_eof_o |-> o_eol_o);

endmodule

// File: rtl/lr_line_joiner.sv
module lr_line_joiner #(
  parameter int MAX_W = 16,
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             l_valid,
  output logic             l_ready,
  input  logic [PIX_W-1:0] l_data,
  input  logic             r_valid,
  output logic             r_ready,
  input  logic [PIX_W-1:0] r_data,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [PIX_W-1:0] o_data,
  output logic             o_eol,
  output logic             o_eof,
  output logic [31:0]      out_size
);

  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam int AW    = $clog2(MAX_W);
  localparam int NBUF  = 2;

  logic             run, mute, join_m;
  logic [15:0]      height;
  logic [CNT_W-1:0] lw, rw, lw_m1, rw_m1;

  logic             wr_valid [NBUF];
  logic             wr_ready [NBUF];
  logic [PIX_W-1:0] wr_data  [NBUF];
  logic             rd_valid [NBUF];
  logic             rd_ready [NBUF];
  logic [PIX_W-1:0] rd_data  [NBUF];
  logic             rd_last  [NBUF];
  logic [AW-1:0]    last     [NBUF];
  logic             seq_b0_ready, seq_b1_ready;

  ljn_cfg #(.MAX_W(MAX_W), .CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .run_o(run), .mute_o(mute), .join_o(join_m), .h_o(height),
    .lw_o(lw), .rw_o(rw), .size_o(out_size)
  );

  always_comb begin
    lw_m1   = lw - 1'b1;
    rw_m1   = rw - 1'b1;
    last[0] = lw_m1[AW-1:0];
    last[1] = join_m ? rw_m1[AW-1:0] : lw_m1[AW-1:0];
    wr_valid[0] = l_valid;
    wr_data[0]  = l_data;
    wr_valid[1] = join_m ? r_valid : rd_valid[0];
    wr_data[1]  = join_m ? r_data  : rd_data[0];
    rd_ready[0] = join_m ? seq_b0_ready : wr_ready[1];
    rd_ready[1] = seq_b1_ready;
    l_ready     = wr_ready[0];
    r_ready     = join_m && wr_ready[1];
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_store
    ljn_line_buf #(.DEPTH(MAX_W), .DW(PIX_W)) buf_i (
      .clk(clk), .rst_n(rst_n), .clr_i(!run), .last_i(last[g]),
      .wr_valid_i(wr_valid[g]), .wr_ready_o(wr_ready[g]), .wr_data_i(wr_data[g]),
      .rd_valid_o(rd_valid[g]), .rd_ready_i(rd_ready[g]), .rd_data_o(rd_data[g]),
      .rd_last_o(rd_last[g])
    );
  end

  ljn_out_seq #(.DW(PIX_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .run_i(run), .mute_i(mute), .join_i(join_m), .h_i(height),
    .b0_valid_i(rd_valid[0]), .b0_data_i(rd_data[0]), .b0_last_i(rd_last[0]),
    .b1_valid_i(rd_valid[1]), .b1_data_i(rd_data[1]), .b1_last_i(rd_last[1]),
    .b0_ready_o(seq_b0_ready), .b1_ready_o(seq_b1_ready),
    .o_valid_o(o_valid), .o_ready_i(o_ready), .o_data_o(o_data),
    .o_eol_o(o_eol), .o_eof_o(o_eof)
  );

  assert_mute_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> !o_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready && run && !mute) |=> (!run || mute || (o_valid && $stable(o_data))));

  assert_right_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !join_m) |-> !r_ready);

  assert_join_both_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (join_m && rd_ready[0]) |-> rd_valid[1]);

  assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!l_ready && !r_ready && !o_valid));

endmodule

// File: tb/lr_line_joiner_tb_top.sv
module lr_line_joiner_tb_top;

  localparam int MAX_W = 16;
  localparam int PIX_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic l_valid = 1'b0, r_valid = 1'b0, o_ready = 1'b0;
  logic [PIX_W-1:0] l_data = '0, r_data = '0;
  logic l_ready, r_ready, o_valid, o_eol, o_eof;
  logic [PIX_W-1:0] o_data;
  logic [31:0] out_size;

  always #4 clk = ~clk;

  lr_line_joiner #(.MAX_W(MAX_W), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .l_valid(l_valid), .l_ready(l_ready), .l_data(l_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data),
    .o_eol(o_eol), .o_eof(o_eof), .out_size(out_size)
  );

  int nvec = 0, nfail = 0;
  bit done = 0;
  int cycles = 0;

  int cur_lw, cur_rw, cur_h, pat;
  int l_idx, r_idx, o_idx, l_total, r_total, o_total;
  bit stream_on = 0, lgate = 1, rgate = 1, mute_b = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] lpix(int k);
    int row = k / cur_lw;
    int col = k % cur_lw;
    return {1'b0, row[6:0], col[7:0]};
  endfunction

  function automatic logic [15:0] rpix(int k);
    int row = k / cur_rw;
    int col = k % cur_rw;
    return {1'b1, row[6:0], col[7:0]};
  endfunction

  // stream engine: drive at negedge, observe settled handshakes 1 ns later
  always @(negedge clk) begin
    if (stream_on) begin
      int w, line, c;
      logic [15:0] ep;
      string tag;
      cyc++;
      o_ready = (pat == 0) ? 1'b1 : ((cyc % 3) != 2);
      l_valid = lgate && (l_idx < l_total) && ((pat == 0) || ((cyc % 4) != 3));
      l_data  = lpix(l_idx);
      r_valid = rgate && (r_idx < r_total) && ((pat == 0) || ((cyc % 5) != 0));
      r_data  = (cur_rw > 0) ? rpix(r_idx) : '0;
      #1;
      if (mute_b && o_valid) chk(0, "R7", "o_valid while muted", 1, 0);
      if (l_valid && l_ready) l_idx++;
      if (r_valid && r_ready) r_idx++;
      if (o_valid && o_ready) begin
        w    = cur_lw + cur_rw;
        line = o_idx / w;
        c    = o_idx % w;
        ep   = (c < cur_lw) ? lpix(line * cur_lw + c) : rpix(line * cur_rw + c - cur_lw);
        tag  = (cur_rw > 0) ? "R3" : "R4";
        chk(o_data == ep, tag, $sformatf("pixel %0d", o_idx), o_data, ep);
        chk(o_eol == (c == w - 1), "R10", $sformatf("eol at %0d", o_idx), o_eol, c == w - 1);
        chk(o_eof == ((c == w - 1) && (line % cur_h == cur_h - 1)), "R10",
            $sformatf("eof at %0d", o_idx), o_eof, (c == w - 1) && (line % cur_h == cur_h - 1));
        o_idx++;
      end
    end else begin
      o_ready = 1'b0;
      l_valid = 1'b0;
      r_valid = 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_cfg(input int lw, input int rw, input int h, input int code);
    wr(3'd2, {h[15:0], lw[15:0]});
    wr(3'd3, {16'd0, rw[15:0]});
    wr(3'd4, {27'd0, code[4:0]});
  endtask

  task automatic arm(input int lw, input int rw, input int h, input int rows);
    cur_lw = lw; cur_rw = rw; cur_h = h;
    l_idx = 0; r_idx = 0; o_idx = 0;
    l_total = rows * lw; r_total = rows * rw; o_total = rows * (lw + rw);
  endtask

  task automatic drain(input string req);
    int wait_cnt = 0;
    stream_on = 1;
    while (o_idx < o_total && wait_cnt < 6000) begin
      @(negedge clk);
      wait_cnt++;
    end
    stream_on = 0;
    @(negedge clk);
    chk(o_idx == o_total, req, "pixels delivered", o_idx, o_total);
  endtask

  task automatic run_case(input int lw, input int rw, input int h, input int code);
    program_cfg(lw, rw, h, code);
    wr(3'd0, 32'd1);
    chk(out_size == {h[15:0], 16'(lw + rw)}, "R2", "out_size", out_size, {h[15:0], 16'(lw + rw)});
    // R8: reprogram while running, must not disturb the active geometry
    program_cfg(7, 9, 1, 0);
    chk(out_size == {h[15:0], 16'(lw + rw)}, "R8", "out_size after write", out_size,
        {h[15:0], 16'(lw + rw)});
    arm(lw, rw, h, 2 * h);
    drain(rw > 0 ? "R3" : "R4");
    wr(3'd0, 32'd0);
    chk(!l_ready && !r_ready && !o_valid, "R6", "quiet after stop",
        {l_ready, r_ready, o_valid}, 0);
  endtask

  task automatic bad_case(input int lw, input int rw, input int h, input int code);
    program_cfg(lw, rw, h, code);
    wr(3'd0, 32'd1);
    repeat (3) @(negedge clk);
    chk(!l_ready && !r_ready, "R5", $sformatf("refused start h%0d l%0d r%0d c%0d", h, lw, rw, code),
        {l_ready, r_ready}, 0);
    wr(3'd0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!l_ready && !r_ready && !o_valid, "R6", "reset state", {l_ready, r_ready, o_valid}, 0);

    bad_case(3, 2, 0, 18);
    bad_case(0, 0, 2, 6);
    bad_case(3, 2, 2, 6);
    bad_case(3, 0, 2, 18);
    bad_case(17, 0, 2, 6);
    bad_case(3, 17, 2, 18);

    // R1 field positions: height 31:16, width 15:0, sweep over widths and heights
    for (int lw = 1; lw <= 6; lw++)
      for (int rw = 0; rw <= 6; rw++)
        for (int h = 1; h <= 3; h++) begin
          pat = (lw + rw + h) % 2;
          run_case(lw, rw, h, rw > 0 ? 18 : ((lw % 2) ? 6 : 8));
        end
    pat = 1;
    run_case(16, 16, 2, 18);
    run_case(16, 0, 2, 8);
    run_case(1, 16, 1, 18);

    // R9: right input stalled, left may get exactly one line ahead
    pat = 0;
    program_cfg(4, 3, 1, 18);
    wr(3'd0, 32'd1);
    arm(4, 3, 1, 2);
    rgate = 0;
    stream_on = 1;
    repeat (40) @(negedge clk);
    chk(l_idx == 4, "R9", "left accepted while right stalled", l_idx, 4);
    chk(o_idx == 0, "R9", "no output before right line", o_idx, 0);
    rgate = 1;
    drain("R9");
    wr(3'd0, 32'd0);

    // R7: mute holds output, nothing lost
    program_cfg(3, 2, 2, 18);
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd1);
    mute_b = 1;
    arm(3, 2, 2, 4);
    stream_on = 1;
    repeat (50) @(negedge clk);
    stream_on = 0;
    chk(o_idx == 0, "R7", "no output while muted", o_idx, 0);
    @(negedge clk);
    chk(!l_ready, "R7", "stores held full while muted", l_ready, 0);
    mute_b = 0;
    wr(3'd1, 32'd0);
    drain("R7");
    wr(3'd0, 32'd0);

    // R6: stop mid-line discards partial lines, restart delivers clean frame
    program_cfg(5, 4, 2, 18);
    wr(3'd0, 32'd1);
    arm(5, 4, 2, 2);
    stream_on = 1;
    repeat (3) @(negedge clk);
    stream_on = 0;
    wr(3'd0, 32'd0);
    chk(!l_ready && !o_valid, "R6", "stopped mid-line", {l_ready, o_valid}, 0);
    wr(3'd0, 32'd1);
    arm(5, 4, 2, 4);
    drain("R6");
    wr(3'd0, 32'd0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule